// File: doc/BRIEF.md
# Parallel Column Readout Serializer

This block drains a pixel matrix column by column and turns the result into a framed stream of 8-bit symbols for a single serial lane. Software picks how many columns are read at once (1, 2, 4 or 8). The columns are split into that many equal groups. Each step reads the same relative column from every group in parallel. Row fetches from the matrix are paced by a clock-enable divider whose ratio is chosen separately from the lane count.

Each parallel step becomes one packet. The packet opens with a start control symbol and a three-byte header. The header carries the lane count, the divider code, the compression flag, the column index and the payload length, so the stream decodes without side information. The payload follows, then an end control symbol.

Symbols carry a control flag for a downstream 8b/10b encoder. A double-data-rate stage shifts each symbol out two bits per clock, LSB first. When no frame runs, the idle control symbol fills the line.

Top module: `rdo_par_readout`

## Requirements
- R1: Out of reset and whenever no frame is running, busy_o is low and every emitted symbol is 0xBC with sym_k_o high.
- R2: start_i is accepted only while busy_o is low. At that edge par_sel_i, div_sel_i and cmp_en_i are captured. Later changes of these inputs, and further start_i pulses while busy_o is high, have no effect on the frame.
- R3: Every packet is, in order: control 0xFB, three header data bytes, the payload data bytes, control 0xFD. Control 0xBC may be inserted anywhere and carries no data.
- R4: The header bytes are as follows.
  - Header byte 0 is {2'b00, cmp, div[2:0], par[1:0]}.
  - Header byte 1 is the group-relative column index k.
  - Header byte 2 is the payload length in bytes, ROWS*N.
- R5: The lane count is N = 2^par and the group size is G = NUM_COLS/N. Packets k = 0..G-1 are sent in order, and packet k reads columns l*G+k for lanes l < N. After G packets the frame ends and busy_o falls. fetch_o is never high while busy_o is low.
- R6: The payload is ordered by row 0..ROWS-1, and within a row by lane 0..N-1. Each byte is the lane's col_data_i value in the cycle where fetch_o is high with row_o equal to that row.
- R7: fetch_o is high only in cycles c where c mod (div+1) equals div. Here c counts from 0 at the first cycle after the accepting edge.
- R8: Each symbol stays on sym_o for four cycles, starting with the sym_vld_o cycle. In the i-th of those cycles (i = 0..3), ddr_rise_o carries bit 2i and ddr_fall_o carries bit 2i+1.
- R9: sym_vld_o is high exactly once in every four cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serializer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a frame |
| par_sel_i | input | 2 | Lane count code, N = 2^code |
| div_sel_i | input | 3 | Fetch divider code, ratio = code+1 |
| cmp_en_i | input | 1 | Compression flag reported in the header |
| busy_o | output | 1 | Frame in progress |
| fetch_o | output | 1 | Row fetch strobe to the matrix |
| col_addr_o | output | 32 | Column address per lane, 4 bits each, lane 0 at the LSBs |
| row_o | output | 3 | Row being fetched |
| col_data_i | input | 64 | Pixel byte per lane, lane 0 at the LSBs, valid while fetch_o is high |
| sym_o | output | 8 | Current symbol |
| sym_k_o | output | 1 | Symbol is a control character |
| sym_vld_o | output | 1 | First cycle of a new symbol |
| ddr_rise_o | output | 1 | Bit sent on the rising half |
| ddr_fall_o | output | 1 | Bit sent on the falling half |

## Verification
The bench runs every lane count, with the divider at both its fastest and slowest setting, and adds seeded random frames. It compares the de-filled symbol stream with a column map built from R5.

Several faults show up directly in this comparison:
- A wrong lane-to-column stride swaps payload bytes between packets.
- An off-by-one in the row or packet count adds or drops a packet or a trailing byte.
- A header built from live inputs instead of captured ones breaks in the frames where the inputs are changed mid-frame and start_i is pulsed again.

Some faults are caught by per-cycle checks instead:
- A divider with the wrong phase fetches outside the allowed residue.
- A serializer that shifts MSB first, or loads off its four-cycle slot, corrupts the checked bit pairs.

Slow dividers with a single lane force fill symbols inside packets. Any design that sends stale buffer bytes instead of a fill is caught there.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  localparam logic [7:0] K_IDLE = 8'hBC;
  localparam logic [7:0] K_SOP  = 8'hFB;
  localparam logic [7:0] K_EOP  = 8'hFD;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SOP, ST_HDR0, ST_HDR1, ST_HDR2, ST_PAY, ST_EOP
  } fr_state_e;

  typedef struct packed {
    logic [1:0] par;
    logic [2:0] div;
    logic       cmp;
  } rdo_cfg_t;
endpackage

// File: rtl/rdo_clk_div.sv
module rdo_clk_div #(
  parameter int DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] ratio_m1_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q == ratio_m1_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (restart_i || tick_o) cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end

  // R7
  tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !restart_i && ratio_m1_i != '0) |=> !tick_o);
endmodule

// File: rtl/rdo_col_sched.sv
module rdo_col_sched #(
  parameter int NUM_COLS = 16,
  parameter int ROWS     = 8,
  parameter int LANES    = 8,
  localparam int COL_W   = $clog2(NUM_COLS),
  localparam int ROW_W   = $clog2(ROWS),
  localparam int LANE_W  = $clog2(LANES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   restart_i,
  input  logic [1:0]             par_i,
  input  logic                   tick_i,
  input  logic                   active_i,
  input  logic                   consume_i,
  input  logic                   next_step_i,
  input  logic [LANES*8-1:0]     col_data_i,
  output logic                   fetch_o,
  output logic [LANES*COL_W-1:0] col_addr_o,
  output logic [ROW_W-1:0]       row_o,
  output logic                   buf_vld_o,
  output logic [7:0]             byte_o,
  output logic                   last_byte_o,
  output logic [COL_W-1:0]       step_o,
  output logic                   last_step_o
);
  localparam logic [ROW_W:0] ROWS_C = (ROW_W+1)'(ROWS);

  logic [COL_W-1:0]       step_q;
  logic [ROW_W:0]         row_cnt_q;
  logic [LANE_W-1:0]      lane_q;
  logic                   buf_vld_q;
  logic [LANES-1:0][7:0]  buf_q;
  logic [LANE_W-1:0]      lanes_m1;
  logic [COL_W-1:0]       grp_last;

  assign lanes_m1    = LANE_W'((1 << par_i) - 1);
  assign grp_last    = COL_W'((NUM_COLS >> par_i) - 1);
  assign fetch_o     = tick_i && active_i && !buf_vld_q && (row_cnt_q < ROWS_C);
  assign row_o       = row_cnt_q[ROW_W-1:0];
  assign buf_vld_o   = buf_vld_q;
  assign byte_o      = buf_q[lane_q];
  assign last_byte_o = (lane_q == lanes_m1) && (row_cnt_q == ROWS_C);
  assign step_o      = step_q;
  assign last_step_o = (step_q == grp_last);

  // lane l reads column l*G + step
  for (genvar l = 0; l < LANES; l++) begin : g_addr
    assign col_addr_o[l*COL_W +: COL_W] = (l < (1 << par_i))
      ? COL_W'((l << (COL_W - int'(par_i))) + int'(step_q)) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q    <= '0;
      row_cnt_q <= '0;
      lane_q    <= '0;
      buf_vld_q <= 1'b0;
      buf_q     <= '0;
    end else if (restart_i || next_step_i) begin
      step_q    <= restart_i ? '0 : step_q + 1'b1;
      row_cnt_q <= '0;
      lane_q    <= '0;
      buf_vld_q <= 1'b0;
    end else begin
      if (fetch_o) begin
        buf_q     <= col_data_i;
        buf_vld_q <= 1'b1;
        row_cnt_q <= row_cnt_q + 1'b1;
      end
      if (consume_i) begin
        if (lane_q == lanes_m1) begin
          lane_q    <= '0;
          buf_vld_q <= 1'b0;
        end else begin
          lane_q <= lane_q + 1'b1;
        end
      end
    end
  end

  // R6
  consume_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consume_i |-> buf_vld_q);
  // R5
  step_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_o |-> (step_q <= grp_last));
endmodule

// File: rtl/rdo_framer.sv
module rdo_framer
  import rdo_pkg::*;
#(
  parameter int ROWS  = 8,
  parameter int COL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slot_i,
  input  logic             start_i,
  input  rdo_cfg_t         cfg_i,
  input  logic             buf_vld_i,
  input  logic [7:0]       byte_i,
  input  logic             last_byte_i,
  input  logic [COL_W-1:0] step_i,
  input  logic             last_step_i,
  output logic [7:0]       sym_o,
  output logic             sym_k_o,
  output logic             busy_o,
  output logic             active_o,
  output logic             consume_o,
  output logic             next_step_o
);
  fr_state_e state_q, state_d;

  assign busy_o      = (state_q != ST_IDLE);
  assign active_o    = busy_o && (state_q != ST_EOP);
  assign consume_o   = slot_i && (state_q == ST_PAY) && buf_vld_i;
  assign next_step_o = slot_i && (state_q == ST_EOP) && !last_step_i;

  always_comb begin
    sym_o   = K_IDLE;
    sym_k_o = 1'b1;
    unique case (state_q)
      ST_SOP:  sym_o = K_SOP;
      ST_EOP:  sym_o = K_EOP;
      ST_HDR0: begin sym_o = {2'b00, cfg_i.cmp, cfg_i.div, cfg_i.par}; sym_k_o = 1'b0; end
      ST_HDR1: begin sym_o = 8'(step_i);                                sym_k_o = 1'b0; end
      ST_HDR2: begin sym_o = 8'(ROWS << cfg_i.par);                     sym_k_o = 1'b0; end
      ST_PAY:  if (buf_vld_i) begin sym_o = byte_i; sym_k_o = 1'b0; end
      default: ;
    endcase
  end

  always_comb begin
    state_d = state_q;
    if (state_q == ST_IDLE) begin
      if (start_i) state_d = ST_SOP;
    end else if (slot_i) begin
      unique case (state_q)
        ST_SOP:  state_d = ST_HDR0;
        ST_HDR0: state_d = ST_HDR1;
        ST_HDR1: state_d = ST_HDR2;
        ST_HDR2: state_d = ST_PAY;
        ST_PAY:  if (buf_vld_i && last_byte_i) state_d = ST_EOP;
        ST_EOP:  state_d = last_step_i ? ST_IDLE : ST_SOP;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/rdo_ddr_ser.sv
module rdo_ddr_ser
  import rdo_pkg::*;
#(
  parameter int SYM_W    = 8,
  localparam int SLOT_CYC = SYM_W / 2,
  localparam int CNT_W    = $clog2(SLOT_CYC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SYM_W-1:0] sym_i,
  input  logic             sym_k_i,
  output logic             slot_o,
  output logic [SYM_W-1:0] sym_o,
  output logic             sym_k_o,
  output logic             sym_vld_o,
  output logic             ddr_rise_o,
  output logic             ddr_fall_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [SYM_W-1:0] sh_q;

  assign slot_o     = (cnt_q == CNT_W'(SLOT_CYC - 1));
  assign ddr_rise_o = sh_q[0];
  assign ddr_fall_o = sh_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      sh_q      <= SYM_W'(K_IDLE);
      sym_o     <= SYM_W'(K_IDLE);
      sym_k_o   <= 1'b1;
      sym_vld_o <= 1'b0;
    end else begin
      cnt_q     <= slot_o ? '0 : cnt_q + 1'b1;
      sym_vld_o <= slot_o;
      if (slot_o) begin
        sh_q    <= sym_i;
        sym_o   <= sym_i;
        sym_k_o <= sym_k_i;
      end else begin
        sh_q <= {2'b00, sh_q[SYM_W-1:2]};
      end
    end
  end

  // R9
  vld_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_vld_o |=> !sym_vld_o);
  // R8
  lsb_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_vld_o |=> (ddr_rise_o == sym_o[2]) && (ddr_fall_o == sym_o[3]));
endmodule

// File: rtl/rdo_par_readout.sv
module rdo_par_readout
  import rdo_pkg::*;
#(
  parameter int NUM_COLS = 16,
  parameter int ROWS     = 8,
  localparam int LANES   = 8,
  localparam int COL_W   = $clog2(NUM_COLS),
  localparam int ROW_W   = $clog2(ROWS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [1:0]             par_sel_i,
  input  logic [2:0]             div_sel_i,
  input  logic                   cmp_en_i,
  output logic                   busy_o,
  output logic                   fetch_o,
  output logic [LANES*COL_W-1:0] col_addr_o,
  output logic [ROW_W-1:0]       row_o,
  input  logic [LANES*8-1:0]     col_data_i,
  output logic [7:0]             sym_o,
  output logic                   sym_k_o,
  output logic                   sym_vld_o,
  output logic                   ddr_rise_o,
  output logic                   ddr_fall_o
);
  rdo_cfg_t         cfg_q;
  logic             start_acc, tick, slot;
  logic             active, consume, next_step;
  logic             buf_vld, last_byte, last_step;
  logic [7:0]       pay_byte, fr_sym;
  logic             fr_k;
  logic [COL_W-1:0] step;

  assign start_acc = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cfg_q <= '0;
    else if (start_acc) cfg_q <= '{par: par_sel_i, div: div_sel_i, cmp: cmp_en_i};
  end

  rdo_clk_div #(.DIV_W(3)) i_div (
    .clk_i, .rst_ni, .restart_i(start_acc), .ratio_m1_i(cfg_q.div), .tick_o(tick)
  );

  rdo_col_sched #(.NUM_COLS(NUM_COLS), .ROWS(ROWS), .LANES(LANES)) i_sched (
    .clk_i, .rst_ni, .restart_i(start_acc), .par_i(cfg_q.par), .tick_i(tick),
    .active_i(active), .consume_i(consume), .next_step_i(next_step),
    .col_data_i, .fetch_o, .col_addr_o, .row_o, .buf_vld_o(buf_vld),
    .byte_o(pay_byte), .last_byte_o(last_byte), .step_o(step), .last_step_o(last_step)
  );

  rdo_framer #(.ROWS(ROWS), .COL_W(COL_W)) i_framer (
    .clk_i, .rst_ni, .slot_i(slot), .start_i(start_acc), .cfg_i(cfg_q),
    .buf_vld_i(buf_vld), .byte_i(pay_byte), .last_byte_i(last_byte),
    .step_i(step), .last_step_i(last_step), .sym_o(fr_sym), .sym_k_o(fr_k),
    .busy_o, .active_o(active), .consume_o(consume), .next_step_o(next_step)
  );

  rdo_ddr_ser #(.SYM_W(8)) i_ser (
    .clk_i, .rst_ni, .sym_i(fr_sym), .sym_k_i(fr_k), .slot_o(slot),
    .sym_o, .sym_k_o, .sym_vld_o, .ddr_rise_o, .ddr_fall_o
  );

  // R1
  idle_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot && !busy_o) |=> (sym_k_o && sym_o == K_IDLE));
  // R5
  no_stray_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_o |-> busy_o);
endmodule

// File: tb/test_rdo_par_readout.sv
module test_rdo_par_readout;
  localparam int NC = 16, NR = 8, COLW = 4;

  logic        clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, cmp_en_i = 1'b0;
  logic [1:0]  par_sel_i = '0;
  logic [2:0]  div_sel_i = '0;
  logic        busy_o, fetch_o, sym_k_o, sym_vld_o, ddr_rise_o, ddr_fall_o;
  logic [31:0] col_addr_o;
  logic [2:0]  row_o;
  logic [63:0] col_data_i;
  logic [7:0]  sym_o;

  int n_chk = 0, n_fail = 0, cyc = 0, c_base = 0, ratio = 1, salt = 0;
  logic [8:0] sym_q[$];

  always #10 clk_i = ~clk_i;

  rdo_par_readout i_rdo_par_readout (.*);

  function automatic logic [7:0] px(input int c, input int r, input int s);
    return 8'(c * 29 + r * 7 + s * 13 + (c ^ (r << 2)));
  endfunction

  always_comb
    for (int l = 0; l < 8; l++)
      col_data_i[l*8 +: 8] = px(int'(col_addr_o[l*COLW +: COLW]), int'(row_o), salt);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      chk(0, "watchdog", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  // symbol, DDR and fetch monitor
  int gap = 0, ph = 4;
  bit seen = 0, ddr_bad = 0;
  logic [7:0] cur;
  always @(negedge clk_i) if (rst_ni) begin
    if (sym_vld_o) begin
      if (seen) chk(gap == 4, "R9", gap, 4);
      seen = 1; gap = 1; ph = 0; cur = sym_o;
      sym_q.push_back({sym_k_o, sym_o});
    end else begin
      gap++; ph++;
    end
    if (seen && ph < 4) begin
      if (ddr_rise_o !== cur[2*ph] || ddr_fall_o !== cur[2*ph+1]) ddr_bad = 1;
      if (ph == 3) begin
        chk(!ddr_bad, "R8", {ddr_fall_o, ddr_rise_o}, cur[7:6]);
        ddr_bad = 0;
      end
    end
    if (fetch_o) begin
      chk(busy_o === 1'b1, "R5", busy_o, 1);
      chk(((cyc - c_base) % ratio) == ratio - 1, "R7", (cyc - c_base) % ratio, ratio - 1);
    end
  end

  task automatic run_frame(input logic [1:0] par, input logic [2:0] div, input logic cmp, input bit poke);
    int n, g, tg[$];
    logic [8:0] exp_q[$], act_q[$];
    string t;
    n = 1 << par; g = NC / n; salt = salt + 1;
    @(negedge clk_i);
    sym_q.delete();
    par_sel_i = par; div_sel_i = div; cmp_en_i = cmp; start_i = 1'b1;
    ratio = int'(div) + 1; c_base = cyc + 1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o === 1'b1, "R2", busy_o, 1);
    if (poke) begin
      repeat (60) @(negedge clk_i);
      par_sel_i = ~par; div_sel_i = ~div; cmp_en_i = ~cmp; start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    while (busy_o) @(negedge clk_i);
    repeat (16) @(negedge clk_i);
    chk(sym_k_o && sym_o == 8'hBC, "R1", {sym_k_o, sym_o}, 9'h1BC);
    for (int k = 0; k < g; k++) begin
      exp_q.push_back(9'h1FB); tg.push_back(3);
      exp_q.push_back({1'b0, 2'b00, cmp, div, par}); tg.push_back(4);
      exp_q.push_back({1'b0, 8'(k)}); tg.push_back(4);
      exp_q.push_back({1'b0, 8'(NR * n)}); tg.push_back(4);
      for (int r = 0; r < NR; r++)
        for (int l = 0; l < n; l++) begin
          exp_q.push_back({1'b0, px(l * g + k, r, salt)}); tg.push_back(6);
        end
      exp_q.push_back(9'h1FD); tg.push_back(3);
    end
    foreach (sym_q[i]) if (sym_q[i] != 9'h1BC) act_q.push_back(sym_q[i]);
    chk(act_q.size() == exp_q.size(), "R5", act_q.size(), exp_q.size());
    foreach (exp_q[i]) begin
      t = (tg[i] == 3) ? "R3" : (tg[i] == 4) ? "R4" : "R6";
      if (i < act_q.size()) chk(act_q[i] == exp_q[i], t, act_q[i], exp_q[i]);
    end
  endtask

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(busy_o === 1'b0, "R1", busy_o, 0);
    chk(fetch_o === 1'b0, "R1", fetch_o, 0);
    chk(sym_k_o && sym_o == 8'hBC, "R1", {sym_k_o, sym_o}, 9'h1BC);
    for (int p = 0; p < 4; p++) run_frame(2'(p), 3'd0, 1'b0, 1'b0);
    run_frame(2'd3, 3'd7, 1'b1, 1'b1);
    run_frame(2'd0, 3'd7, 1'b0, 1'b1);
    run_frame(2'd1, 3'd3, 1'b1, 1'b0);
    for (int i = 0; i < 8; i++)
      run_frame(2'($urandom % 4), 3'($urandom % 8), 1'($urandom % 2), 1'($urandom % 2));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule